// File: doc/BRIEF.md
# Masked Interrupt Request Generator

This block merges eight event flags from a two-channel serial controller into one interrupt request line. Each flag has a matching bit in a mask register that software writes. The request line is high whenever at least one flag and its mask bit are both set. The mask register cannot be read back. Software can read the flags at any time, and it always sees the raw flags with no masking applied.

Bit n of the mask controls flag n. The flags, from bit 7 down to bit 0, are:

- channel-independent change-of-state
- channel B break change
- channel B receive ready
- channel B transmit ready
- oscillator-ready
- channel A break change
- channel A receive ready
- channel A transmit ready

The oscillator-ready flag can be read but can never raise the request. While the controller's stop input is high, writes to the mask are dropped. The request output is registered.

Top module: `sio_irq_combiner`

## Requirements
- R1: After a synchronous reset the mask is all zeros and `irq_o` is 0.
- R2: When some status bit n and mask bit n are both 1 at a rising edge, `irq_o` is 1 after that edge. The output therefore follows a status change by one clock. It follows a mask write by two clocks: one to load the mask and one to register the request.
- R3: A status bit whose mask bit is 0 never drives `irq_o` high.
- R4: With `rd_sel_i` = 0, `rd_data_o` equals `status_i` on the same cycle, whatever the mask holds.
- R5: Status bit 3 (oscillator-ready) never causes `irq_o`, even after the value 1 is written to mask bit 3.
- R6: A mask write (`wr_stb_i` = 1) while `stop_i` = 1 leaves the mask unchanged.
- R7: With `rd_sel_i` = 1 (the mask address), `rd_data_o` reads all zeros.
- R8: When no status bit is paired with a set mask bit at a rising edge, `irq_o` is 0 after that edge.
- R9: Positions: bit 7 change-of-state, 6 break B, 5 receive B, 4 transmit B, 3 oscillator-ready, 2 break A, 1 receive A, 0 transmit A. Mask bit n pairs only with status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_i | input | 1 | Controller stopped; blocks mask writes |
| wr_stb_i | input | 1 | Mask write strobe |
| wr_data_i | input | 8 | Mask write value |
| status_i | input | 8 | Raw status flags |
| rd_sel_i | input | 1 | Read select: 0 status, 1 mask address |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The mask is first set to a single bit while the matching status bit and then its neighbours are driven. This separates a true pairing from a shifted or swapped bit lane. An all-ones mask against the lone oscillator-ready flag tests the permanent lockout. A mask write issued while stopped, followed by flags that only the old mask would pass, shows that the write was dropped. Status reads are made while the mask is empty, full and partial, which shows that the mask never leaks into the read path.

// File: rtl/sio_irq_pkg.sv
// Shared constants and types for the serial interrupt combiner.
// Assumes an 8-bit flag vector with the oscillator-ready flag at bit 3.
package sio_irq_pkg;
    localparam int IRQ_W    = 8;
    localparam int OSC_BIT  = 3;
    localparam logic [IRQ_W-1:0] LOCK_MASK = IRQ_W'(1) << OSC_BIT;

    typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/sio_irq_mask_reg.sv
// Write-only mask register. Loads on a write strobe while the controller runs.
// Bits flagged in LOCK are tied to zero, so they can never be set.
// Assumes a synchronous active-low reset.
module sio_irq_mask_reg #(
    parameter int          W    = 8,
    parameter logic [W-1:0] LOCK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_i,
    input  logic         wr_stb_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] mask_o
);
    logic load;

    // Decide whether this cycle may update the mask
    always_comb load = wr_stb_i && !stop_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LOCK[i]) begin : g_locked
            // Locked lane: always reads as disabled
            assign mask_o[i] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // Hold or load one mask bit
            always_ff @(posedge clk) begin
                if (!rst_n)     bit_q <= 1'b0;
                else if (load)  bit_q <= wr_data_i[i];
            end
            assign mask_o[i] = bit_q;
        end
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (mask_o == $past(mask_o)));  // R6
endmodule

// File: rtl/sio_irq_reduce.sv
// Pairs each flag with its mask bit and registers the OR of the pairs.
// Assumes mask and status are valid at each rising edge.
module sio_irq_reduce #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] hit;
    logic         any_hit;
    logic         irq_q;

    for (genvar i = 0; i < W; i++) begin : g_pair
        // One lane: flag passes only when its mask bit is set
        assign hit[i] = status_i[i] & mask_i[i];
    end

    // Collapse the lanes into a single request
    always_comb any_hit = |hit;

    // Register the request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_hit;
    end

    assign irq_o = irq_q;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & mask_i)) |=> irq_o);  // R2
    AST_IRQ_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_i & mask_i)) |=> !irq_o);  // R8
endmodule

// File: rtl/sio_irq_readmux.sv
// Read path: raw status at address 0, zeros at the write-only mask address.
// Purely combinational; assumes the caller samples within the cycle.
module sio_irq_readmux #(
    parameter int W = 8
) (
    input  logic         rd_sel_i,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] rd_data_o
);
    // Pick the unmasked flags or the write-only placeholder
    always_comb rd_data_o = rd_sel_i ? '0 : status_i;
endmodule

// File: rtl/sio_irq_combiner.sv
// Top level: mask register, request reduction and read path.
// Assumes stop_i comes from the controller's run/stop control, already in this clock domain.
module sio_irq_combiner
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic             wr_stb_i,
    input  logic [IRQ_W-1:0] wr_data_i,
    input  logic [IRQ_W-1:0] status_i,
    input  logic             rd_sel_i,
    output logic [IRQ_W-1:0] rd_data_o,
    output logic             irq_o
);
    irq_vec_t mask;

    sio_irq_mask_reg #(.W(IRQ_W), .LOCK(LOCK_MASK)) u_mask (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
        .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i), .mask_o(mask)
    );

    sio_irq_reduce #(.W(IRQ_W)) u_reduce (
        .clk(clk), .rst_n(rst_n), .status_i(status_i),
        .mask_i(mask), .irq_o(irq_o)
    );

    sio_irq_readmux #(.W(IRQ_W)) u_read (
        .rd_sel_i(rd_sel_i), .status_i(status_i), .rd_data_o(rd_data_o)
    );

    AST_OSC_ALONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == LOCK_MASK) |=> !irq_o);  // R5
endmodule

// File: tb/sio_irq_combiner_test.sv
`timescale 1ns/100ps
module sio_irq_combiner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] status_i = '0;
    logic       rd_sel_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_mask = '0;
    localparam logic [7:0] LIVE = 8'hF7;

    logic  q_irq[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    sio_irq_combiner uut (.*);

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle, check the read path, queue the expected request
    task automatic step(input logic stp, input logic wr, input logic [7:0] wd,
                        input logic [7:0] st, input logic sel, input string tag);
        logic [7:0] exp_rd;
        @(negedge clk);
        stop_i = stp; wr_stb_i = wr; wr_data_i = wd; status_i = st; rd_sel_i = sel;
        #0.5;
        exp_rd = sel ? 8'h00 : st;
        check(rd_data_o === exp_rd, sel ? "R7 mask read" : "R4 status read", rd_data_o, exp_rd);
        q_irq.push_back(|(st & m_mask & LIVE));
        q_tag.push_back(tag);
        if (wr && !stp) m_mask = wd & LIVE;
    endtask

    // Monitor: compare the registered request after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_irq.size() > 0) begin
                logic  e;
                string t;
                e = q_irq.pop_front();
                t = q_tag.pop_front();
                check(irq_o === e, t, {7'b0, irq_o}, {7'b0, e});
            end
        end
    end

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(irq_o === 1'b0, "R1 reset irq", {7'b0, irq_o}, 8'h00);
        rd_sel_i = 1'b1; #0.1;
        check(rd_data_o === 8'h00, "R1 R7 reset mask read", rd_data_o, 8'h00);
        // R1: empty mask blocks everything
        step(0, 0, 8'h00, 8'hFF, 0, "R1 empty mask");
        // R2 / R9 bit 0
        step(0, 1, 8'h01, 8'h00, 0, "R2 load mask");
        step(0, 0, 8'h00, 8'h01, 1, "R2 pair bit0");
        step(0, 0, 8'h00, 8'h02, 0, "R3 unpaired bit1");
        step(0, 0, 8'h00, 8'h00, 0, "R8 clear");
        // R5: full mask, only oscillator flag
        step(0, 1, 8'hFF, 8'h08, 0, "R5 write ones");
        step(0, 0, 8'h00, 8'h08, 0, "R5 osc alone");
        step(0, 0, 8'h00, 8'h88, 1, "R5 R2 with cos");
        // R6: write while stopped is dropped
        step(1, 1, 8'h00, 8'h00, 0, "R6 stopped write");
        step(1, 0, 8'h00, 8'h80, 0, "R6 old mask kept");
        step(0, 1, 8'h04, 8'h80, 0, "R6 run write");
        step(0, 0, 8'h00, 8'h80, 0, "R3 R8 after reload");
        step(0, 0, 8'h00, 8'h04, 0, "R9 bit2");
        // R9: walk each lane, then its neighbours
        for (int i = 0; i < 8; i++) begin
            step(0, 1, 8'(1 << i), 8'h00, 0, "R9 walk load");
            step(0, 0, 8'h00, 8'(1 << i), 0, "R9 walk pair");
            step(0, 0, 8'h00, ~8'(1 << i), 1, "R9 R3 walk others");
        end
        // R4: status reads with a full mask
        step(0, 1, 8'hFF, 8'h5A, 0, "R4 full mask");
        step(0, 0, 8'h00, 8'hA5, 0, "R4 R2 read");
        step(0, 0, 8'h00, 8'h00, 1, "R8 idle");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule